// File: doc/BRIEF.md
# Sequential Signed Booth Multiplier

This block multiplies two signed two's-complement operands over several clock cycles, one multiplier bit per cycle. It uses radix-2 Booth recoding. A single double-width product register is used: its upper half holds the running partial sum and its lower half starts out holding the multiplier. One extra flip-flop holds the multiplier bit that was examined last. On each step, the current low bit of the product register and that saved bit together pick one of three actions on the upper half: add the multiplicand, subtract it, or leave the upper half alone. The whole register then shifts right by one place, and the sign bit is copied into the top position.

A client asserts `start` for one cycle while the block is idle. The operands are captured on that edge. `busy` stays high for exactly `OP_W` cycles. `done` then pulses for one cycle, and `product` holds the full signed result until the next accepted start. The operand width is a parameter, with a default of 32 bits. A second parameter chooses how the add/subtract stage is built.

Top module: `booth_mul_seq`

## Requirements
- R1: After reset (asynchronous, active low) `busy` and `done` are 0 and `product` is all zeros; a reset during an operation aborts it with the same result.
- R2: A `start` seen while `busy` is 0 makes `busy` 1 on the next cycle; `busy` stays high for exactly `OP_W` cycles, and `done` is 1 in the first cycle after `busy` falls.
- R3: When `done` is 1, `product` equals the 2·`OP_W`-bit signed product of the operands captured at the accepted start, for any operand values.
- R4: A multiplicand equal to the most negative value (only the top bit set) gives the exact product, including when the multiplier is also the most negative value (result 2^(2·OP_W−2)) and when it is −1.
- R5: While `busy` is 1, `start` and any change of the operand inputs have no effect: the running operation finishes on schedule with the originally captured operands.
- R6: While idle and without a new start, `product` keeps its value from cycle to cycle.
- R7: Recoding on the pair (current low bit, previous bit): 01 adds the multiplicand to the upper half, 10 subtracts it, 00 and 11 leave it unchanged. The previous bit is 0 at the start. For a multiplier of all ones the result is the negated multiplicand, and for an alternating 0101… multiplier every step does an add or a subtract.
- R8: `done` is a single-cycle pulse and is never 1 in the same cycle as `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | OP_W | Signed multiplicand |
| mplier | input | OP_W | Signed multiplier |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2·OP_W | Signed product |

## Verification
The bound checker watches the handshake on every cycle. It checks that `done` lasts one cycle, never overlaps `busy`, and follows the fall of `busy`. It checks that a busy run lasts exactly `OP_W` cycles, that an accepted start raises `busy`, and that `product` stays still while idle. The numeric correctness of the result can only be shown by the bench's scenarios, which compare against a signed product computed in the bench. These scenarios cover the recoding patterns, the most negative operand, the zero operand, two negative operands, a restart attempted mid-run, and reset during a run.

// File: rtl/booth_pkg.sv
package booth_pkg;

   // Action applied to the upper half of the product in one step.
   typedef enum logic [1:0] {
      BOP_NONE = 2'b00,
      BOP_ADD  = 2'b01,
      BOP_SUB  = 2'b10
   } booth_op_e;

   // Adder construction choice.
   localparam int unsigned ADDER_INVERT = 0;  // one adder, inverted operand + carry-in
   localparam int unsigned ADDER_DUAL   = 1;  // separate sum and difference, then select

   // Pair is {current low bit, previously examined bit}.
   function automatic booth_op_e booth_recode(input logic cur, input logic prev);
      booth_op_e r;
      unique case ({cur, prev})
         2'b01:   r = BOP_ADD;   // end of a run of ones
         2'b10:   r = BOP_SUB;   // start of a run of ones
         default: r = BOP_NONE;  // inside a run of zeros or ones
      endcase
      return r;
   endfunction

endpackage

// File: rtl/booth_recode.sv
module booth_recode
   import booth_pkg::*;
(
   input  logic      cur_bit,
   input  logic      prev_bit,
   output booth_op_e op
);

   always_comb begin
      op = booth_recode(cur_bit, prev_bit);
   end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
   import booth_pkg::*;
#(
   parameter int unsigned W          = 32,
   parameter int unsigned ADD_STYLE  = ADDER_INVERT
) (
   input  logic [W-1:0] upper,
   input  logic [W-1:0] mcand,
   input  booth_op_e    op,
   output logic [W:0]   sum   // one bit wider, sign extended
);

   localparam int unsigned EW = W + 1;

   logic [EW-1:0] up_ext;
   logic [EW-1:0] mc_ext;

   assign up_ext = {upper[W-1], upper};
   assign mc_ext = {mcand[W-1], mcand};

   if (ADD_STYLE == ADDER_INVERT) begin : g_invert
      logic [EW-1:0] opnd;
      logic [EW-1:0] cin;
      always_comb begin
         unique case (op)
            BOP_ADD: opnd = mc_ext;
            BOP_SUB: opnd = ~mc_ext;
            default: opnd = '0;
         endcase
         cin = {{(EW-1){1'b0}}, (op == BOP_SUB)};
      end
      assign sum = up_ext + opnd + cin;
   end else begin : g_dual
      logic [EW-1:0] plus;
      logic [EW-1:0] minus;
      assign plus  = up_ext + mc_ext;
      assign minus = up_ext - mc_ext;
      always_comb begin
         unique case (op)
            BOP_ADD: sum = plus;
            BOP_SUB: sum = minus;
            default: sum = up_ext;
         endcase
      end
   end

endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl #(
   parameter int unsigned ITER = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic load,
   output logic step
);

   localparam int unsigned CNT_W = $clog2(ITER + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ITER - 1);

   logic [CNT_W-1:0] count;

   assign load = start & ~busy;
   assign step = busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         done  <= 1'b0;
         count <= '0;
      end else begin
         done <= 1'b0;
         if (load) begin
            busy  <= 1'b1;
            count <= '0;
         end else if (step) begin
            count <= count + 1'b1;
            if (count == LAST) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/booth_mul_seq.sv
module booth_mul_seq
   import booth_pkg::*;
#(
   parameter int unsigned OP_W      = 32,
   parameter int unsigned ADD_STYLE = ADDER_INVERT,
   localparam int unsigned PROD_W   = 2 * OP_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [OP_W-1:0]   mcand,
   input  logic [OP_W-1:0]   mplier,
   output logic              busy,
   output logic              done,
   output logic [PROD_W-1:0] product
);

   if (OP_W < 2) begin : g_bad_width
      $error("booth_mul_seq: OP_W must be at least 2");
   end
   if (ADD_STYLE > ADDER_DUAL) begin : g_bad_style
      $error("booth_mul_seq: unknown ADD_STYLE");
   end

   logic            load;
   logic            step;
   logic [OP_W-1:0] acc;      // upper half of product register
   logic [OP_W-1:0] lo;       // lower half, starts as multiplier
   logic            prev;     // last bit shifted out
   logic [OP_W-1:0] mcand_r;
   booth_op_e       op;
   logic [OP_W:0]   sum;

   booth_ctrl #(.ITER(OP_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .busy  (busy),
      .done  (done),
      .load  (load),
      .step  (step)
   );

   booth_recode u_rec (
      .cur_bit  (lo[0]),
      .prev_bit (prev),
      .op       (op)
   );

   booth_addsub #(.W(OP_W), .ADD_STYLE(ADD_STYLE)) u_add (
      .upper (acc),
      .mcand (mcand_r),
      .op    (op),
      .sum   (sum)
   );

   // Arithmetic right shift of {sum, lo}: the extra sum bit supplies the sign.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc     <= '0;
         lo      <= '0;
         prev    <= 1'b0;
         mcand_r <= '0;
      end else if (load) begin
         acc     <= '0;
         lo      <= mplier;
         prev    <= 1'b0;
         mcand_r <= mcand;
      end else if (step) begin
         acc  <= sum[OP_W:1];
         lo   <= {sum[0], lo[OP_W-1:1]};
         prev <= lo[0];
      end
   end

   assign product = {acc, lo};

endmodule

// File: rtl/booth_mul_chk.sv
module booth_mul_chk #(
   parameter int unsigned OP_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic [2*OP_W-1:0] product
);

   localparam int unsigned CW = $clog2(OP_W + 2);
   localparam logic [CW-1:0] RUN_LEN = CW'(OP_W);

   logic [CW-1:0] run_cnt;  // busy cycles in the current or just-ended run

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run_cnt <= '0;
      else if (busy) run_cnt <= run_cnt + 1'b1;
      else           run_cnt <= '0;
   end

   AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);                                     // R2
   AST_RUN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_cnt == RUN_LEN));                          // R2
   AST_RUN_NOT_LONG: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < RUN_LEN));                                  // R5
   AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);                                          // R2
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                // R8
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && busy));                                               // R8
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(product));                        // R6

endmodule

bind booth_mul_seq booth_mul_chk #(.OP_W(OP_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .product (product)
);

// File: tb/booth_mul_seq_test.sv
module booth_mul_seq_test;

   localparam int unsigned W  = 32;
   localparam int unsigned NV = 12;

   // {multiplicand, multiplier}
   localparam logic [2*W-1:0] VEC [NV] = '{
      {32'd3,          32'd6},
      {32'hFFFF_FFFD,  32'd6},
      {32'hFFFF_FFF9,  32'hFFFF_FFF7},
      {32'd0,          32'h1234_5678},
      {32'h8765_4321,  32'd0},
      {32'h1234_5678,  32'hFFFF_FFFF},
      {32'hDEAD_BEEF,  32'h5555_5555},
      {32'h7FFF_FFFF,  32'h7FFF_FFFF},
      {32'hFFFF_FFFF,  32'hFFFF_FFFF},
      {32'h0000_0001,  32'h8000_0000},
      {32'hAAAA_AAAA,  32'hAAAA_AAAA},
      {32'h0001_0000,  32'hFFFF_0000}
   };

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [W-1:0]    mcand = '0;
   logic [W-1:0]    mplier = '0;
   logic            busy;
   logic            done;
   logic [2*W-1:0]  product;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   booth_mul_seq #(.OP_W(W)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .mcand   (mcand),
      .mplier  (mplier),
      .busy    (busy),
      .done    (done),
      .product (product)
   );

   task automatic check(input string req, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
      longint sa = longint'($signed(a));
      longint sb = longint'($signed(b));
      return 64'(sa * sb);
   endfunction

   // Runs one multiplication; optional disturbance mid-run.
   task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                          input string req, input bit disturb);
      int n;
      @(negedge clk);
      mcand = a; mplier = b; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check("R2 busy after start", 64'(busy), 64'd1);
      n = 0;
      while (!done && n < 40) begin
         if (disturb && n == 5) begin
            start = 1'b1; mcand = ~a; mplier = b ^ 32'h0F0F_0F0F;
         end else if (disturb && n == 6) begin
            start = 1'b0;
         end
         @(negedge clk);
         n++;
      end
      start = 1'b0;
      check("R2 cycles start to done", 64'(n), 64'(W));
      check(req, product, ref_mul(a, b));
      @(negedge clk);
      check("R8 done single pulse", 64'(done), 64'd0);
      check("R6 product held idle", product, ref_mul(a, b));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R2 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 busy in reset", 64'(busy), 64'd0);
      check("R1 done in reset", 64'(done), 64'd0);
      check("R1 product in reset", product, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R7: table of operand pairs
      for (int i = 0; i < NV; i++) begin
         run_mul(VEC[i][2*W-1:W], VEC[i][W-1:0], "R3 R7 table product", 1'b0);
      end

      // R4: most negative multiplicand
      run_mul(32'h8000_0000, 32'h8000_0000, "R4 min times min", 1'b0);
      run_mul(32'h8000_0000, 32'hFFFF_FFFF, "R4 min times -1", 1'b0);
      run_mul(32'h8000_0000, 32'd7, "R4 min times 7", 1'b0);

      // R5: restart and operand changes during busy are ignored
      run_mul(32'hFFFF_FF85, 32'h0000_3039, "R5 ignore start while busy", 1'b1);

      // R6: idle for several cycles, product unchanged
      repeat (10) @(negedge clk);
      check("R6 product after idle", product, ref_mul(32'hFFFF_FF85, 32'h0000_3039));

      // R3: pseudo-random operands
      for (int i = 0; i < 40; i++) begin
         run_mul($urandom, $urandom, "R3 random product", 1'b0);
      end

      // R1: reset in the middle of a run
      @(negedge clk);
      mcand = 32'd99; mplier = 32'd77; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 busy after mid-run reset", 64'(busy), 64'd0);
      check("R1 product after mid-run reset", product, 64'd0);
      rst_n = 1'b1;
      run_mul(32'd99, 32'd77, "R3 product after reset", 1'b0);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule